// File: doc/BRIEF.md
# Integer ALU with Compare Flags

This block is the arithmetic and logic stage of a small 32-bit integer core. Each cycle the decoder gives it two operands and a select vector with one bit for each operation. The block returns the 32-bit result in the same cycle, with no register on that path. Thirteen operations are available: addition, subtraction, low-word multiplication, signed division and remainder, bitwise and, or and invert, three kinds of shift, a pass-through move and a signed compare.

Only the compare operation has state. It writes two flags, greater-than and equal, into a small register at the next clock edge. The flags then stay as they are until the next compare, so conditional branches later in the program can test them. Every other operation, division by zero, and a malformed select vector all leave the flags unchanged.

Top module: `int_alu_cmp`

## Requirements
- R1: Addition (op_i bit 0) and subtraction (op_i bit 1) give A+B and A-B modulo 2^32.
- R2: Multiplication (op_i bit 2) gives the low 32 bits of A*B.
- R3: Division (op_i bit 3) treats A and B as signed and rounds the quotient toward zero. The case 0x80000000 / 0xFFFFFFFF gives 0x80000000.
- R4: Remainder (op_i bit 4) gives A - B*(A/B) using the quotient of R3, so a nonzero result has the sign of A. 0x80000000 mod 0xFFFFFFFF gives 0.
- R5: With B equal to zero, both division and remainder give 0.
- R6: And (op_i bit 6) gives A&B and or (op_i bit 7) gives A|B. Invert (op_i bit 8) gives ~B and move (op_i bit 12) gives B. In all four, A has no effect.
- R7: The shift amount is B[4:0]. Left shift (op_i bit 9) and logical right shift (op_i bit 10) fill with zeros. Arithmetic right shift (op_i bit 11) fills with A[31].
- R8: Compare (op_i bit 5) gives a result of 0. At the next rising clk edge, eq_o becomes 1 if A==B, and gt_o becomes 1 if A>B as signed numbers.
- R9: Any operation other than compare leaves gt_o and eq_o unchanged. This includes division or remainder by zero.
- R10: When op_i does not have exactly one bit set, result_o is 0 and the flags are unchanged.
- R11: While rst_n is low, gt_o and eq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 13 | One-hot operation select |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, also holds the shift amount |
| result_o | output | 32 | Result of the selected operation, combinational |
| gt_o | output | 1 | Flag from the last compare: A greater than B |
| eq_o | output | 1 | Flag from the last compare: A equal to B |

## Verification
Random operations are run with operands drawn from a mix of fully random words and values placed on the boundaries: 0, 1, all ones, the most negative value and the most positive value. This mix separates a truncating division from a flooring one, a remainder that takes the dividend's sign from one that takes the divisor's, and a sign-filling shift from a zero-filling one. Directed cases come next: overflow on both add and multiply, the most negative value divided by -1, division by zero run just after a compare, shift amounts of 32 or more, and select vectors with zero bits set or two bits set. Each of these cases shows whether the flags kept their value or were overwritten.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int OP_ADD  = 0;
    localparam int OP_SUB  = 1;
    localparam int OP_MUL  = 2;
    localparam int OP_DIV  = 3;
    localparam int OP_MOD  = 4;
    localparam int OP_CMP  = 5;
    localparam int OP_AND  = 6;
    localparam int OP_OR   = 7;
    localparam int OP_NOT  = 8;
    localparam int OP_LSL  = 9;
    localparam int OP_LSR  = 10;
    localparam int OP_ASR  = 11;
    localparam int OP_MOV  = 12;
    localparam int NUM_OPS = 13;

    typedef struct packed {
        logic gt;
        logic eq;
    } cmp_flags_t;
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum,
    output logic [WIDTH-1:0] diff,
    output logic [WIDTH-1:0] prod
);
    assign sum  = a + b;
    assign diff = a - b;
    assign prod = a * b;

    // R1: adding B back to the difference must give A again
    always_comb begin
        a_r1_sub_inverse: assert (diff + b == a);
    end
endmodule

// File: rtl/alu_divmod.sv
module alu_divmod #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] quo,
    output logic [WIDTH-1:0] rem
);
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    always_comb begin
        if (b == '0) begin
            quo = '0;
            rem = '0;
        end else if (a == MOST_NEG && b == '1) begin
            quo = MOST_NEG;
            rem = '0;
        end else begin
            quo = $signed(a) / $signed(b);
            rem = $signed(a) % $signed(b);
        end
    end

    logic [WIDTH-1:0] rem_mag, b_mag;
    assign rem_mag = rem[WIDTH-1] ? (~rem + 1'b1) : rem;
    assign b_mag   = b[WIDTH-1]   ? (~b + 1'b1)   : b;

    always_comb begin
        // R4: the remainder is smaller than the divisor and has the dividend's sign
        if (b != '0) begin
            a_r4_rem_bound: assert (rem_mag < b_mag);
        end
        if (rem != '0) begin
            a_r4_rem_sign: assert (rem[WIDTH-1] == a[WIDTH-1]);
        end
        // R5: a zero divisor gives zero for both outputs
        if (b == '0) begin
            a_r5_div_zero: assert (quo == '0 && rem == '0);
        end
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] a,
    input  logic [SHW-1:0]   amt,
    output logic [WIDTH-1:0] shl,
    output logic [WIDTH-1:0] shr,
    output logic [WIDTH-1:0] sra
);
    assign shl = a << amt;
    assign shr = a >> amt;
    assign sra = $signed(a) >>> amt;

    // R7: the arithmetic shift keeps the sign bit, the logical one clears it when it moves
    always_comb begin
        a_r7_asr_sign: assert (sra[WIDTH-1] == a[WIDTH-1]);
        if (amt != '0) begin
            a_r7_lsr_zero_fill: assert (shr[WIDTH-1] == 1'b0);
        end
    end
endmodule

// File: rtl/int_alu_cmp.sv
module int_alu_cmp
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_OPS-1:0]   op_i,
    input  logic [WIDTH-1:0]     a_i,
    input  logic [WIDTH-1:0]     b_i,
    output logic [WIDTH-1:0]     result_o,
    output logic                 gt_o,
    output logic                 eq_o
);
    localparam int SHW = $clog2(WIDTH);

    typedef struct packed {
        cmp_flags_t flags;
    } alu_state_t;

    logic [WIDTH-1:0] sum, diff, prod, quo, rem, shl, shr, sra;
    logic [WIDTH-1:0] res_by_op [NUM_OPS];
    logic [WIDTH-1:0] gated     [NUM_OPS];
    logic             sel_ok;
    alu_state_t       state_d, state_q;

    alu_arith #(.WIDTH(WIDTH)) u_arith (
        .a(a_i), .b(b_i), .sum(sum), .diff(diff), .prod(prod)
    );

    alu_divmod #(.WIDTH(WIDTH)) u_divmod (
        .a(a_i), .b(b_i), .quo(quo), .rem(rem)
    );

    alu_shift #(.WIDTH(WIDTH), .SHW(SHW)) u_shift (
        .a(a_i), .amt(b_i[SHW-1:0]), .shl(shl), .shr(shr), .sra(sra)
    );

    assign sel_ok = $onehot(op_i);

    always_comb begin
        res_by_op[OP_ADD] = sum;
        res_by_op[OP_SUB] = diff;
        res_by_op[OP_MUL] = prod;
        res_by_op[OP_DIV] = quo;
        res_by_op[OP_MOD] = rem;
        res_by_op[OP_CMP] = '0;
        res_by_op[OP_AND] = a_i & b_i;
        res_by_op[OP_OR]  = a_i | b_i;
        res_by_op[OP_NOT] = ~b_i;
        res_by_op[OP_LSL] = shl;
        res_by_op[OP_LSR] = shr;
        res_by_op[OP_ASR] = sra;
        res_by_op[OP_MOV] = b_i;
    end

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_gate
        assign gated[g] = op_i[g] ? res_by_op[g] : '0;
    end

    always_comb begin
        result_o = '0;
        if (sel_ok) begin
            for (int i = 0; i < NUM_OPS; i++) begin
                result_o = result_o | gated[i];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        if (sel_ok && op_i[OP_CMP]) begin
            state_d.flags.gt = $signed(a_i) > $signed(b_i);
            state_d.flags.eq = (a_i == b_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign gt_o = state_q.flags.gt;
    assign eq_o = state_q.flags.eq;

    // R8: a compare sets the equal flag at the next edge
    a_r8_cmp_eq: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ok && op_i[OP_CMP]) |=> (eq_o == ($past(a_i) == $past(b_i))));

    // R8: a compare sets the greater-than flag at the next edge
    a_r8_cmp_gt: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ok && op_i[OP_CMP]) |=> (gt_o == ($signed($past(a_i)) > $signed($past(b_i)))));

    // R8: the two flags are never both set
    a_r8_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(gt_o && eq_o));

    // R9: anything other than a valid compare leaves the flags alone
    a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_ok && op_i[OP_CMP]) |=> $stable({gt_o, eq_o}));

    // R10: a malformed select gives a zero result
    a_r10_bad_sel_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$onehot(op_i) |-> (result_o == '0));

    // R11: the flags read zero during reset
    a_r11_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (!gt_o && !eq_o));
endmodule

// File: tb/int_alu_cmp_tb.sv
module int_alu_cmp_tb;
    import alu_pkg::*;

    localparam logic [31:0] MOST_NEG = 32'h8000_0000;
    localparam logic [31:0] MOST_POS = 32'h7FFF_FFFF;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_OPS-1:0] op_i = '0;
    logic [31:0]        a_i = '0;
    logic [31:0]        b_i = '0;
    logic [31:0]        result_o;
    logic               gt_o, eq_o;

    int  n_checks = 0;
    int  n_fail = 0;
    logic exp_gt = 1'b0;
    logic exp_eq = 1'b0;

    always #4 clk = ~clk;

    int_alu_cmp #(.WIDTH(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .result_o(result_o), .gt_o(gt_o), .eq_o(eq_o)
    );

    function automatic logic [31:0] model(input int idx, input logic [31:0] a, input logic [31:0] b);
        logic signed [31:0] sa, sb;
        sa = a;
        sb = b;
        case (idx)
            OP_ADD: return a + b;
            OP_SUB: return a - b;
            OP_MUL: return a * b;
            OP_DIV: begin
                if (b == 0) return 32'd0;
                if (a == MOST_NEG && b == 32'hFFFF_FFFF) return MOST_NEG;
                return sa / sb;
            end
            OP_MOD: begin
                if (b == 0) return 32'd0;
                if (a == MOST_NEG && b == 32'hFFFF_FFFF) return 32'd0;
                return sa % sb;
            end
            OP_AND: return a & b;
            OP_OR:  return a | b;
            OP_NOT: return ~b;
            OP_LSL: return a << b[4:0];
            OP_LSR: return a >> b[4:0];
            OP_ASR: return sa >>> b[4:0];
            OP_MOV: return b;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input int idx, input logic [31:0] b);
        case (idx)
            OP_ADD, OP_SUB: return "R1";
            OP_MUL: return "R2";
            OP_DIV: return (b == 0) ? "R5" : "R3";
            OP_MOD: return (b == 0) ? "R5" : "R4";
            OP_CMP: return "R8";
            OP_LSL, OP_LSR, OP_ASR: return "R7";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 7))
            0: return 32'd0;
            1: return 32'd1;
            2: return 32'hFFFF_FFFF;
            3: return MOST_NEG;
            4: return MOST_POS;
            5: return $urandom_range(0, 40);
            default: return $urandom;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, check the combinational result, then the flags after the rising edge
    task automatic apply(input logic [NUM_OPS-1:0] sel, input logic [31:0] a, input logic [31:0] b,
                         input string req);
        logic [31:0] exp_res;
        string       flag_req;
        @(negedge clk);
        op_i = sel;
        a_i  = a;
        b_i  = b;
        exp_res = 32'd0;
        flag_req = "R10";
        if ($onehot(sel)) begin
            for (int i = 0; i < NUM_OPS; i++) begin
                if (sel[i]) exp_res = model(i, a, b);
            end
            flag_req = sel[OP_CMP] ? "R8" : "R9";
        end
        #1;
        check(req, result_o, exp_res);
        if ($onehot(sel) && sel[OP_CMP]) begin
            exp_gt = $signed(a) > $signed(b);
            exp_eq = (a == b);
        end
        @(posedge clk);
        #1;
        check(flag_req, {30'd0, gt_o, eq_o}, {30'd0, exp_gt, exp_eq});
    endtask

    task automatic apply_op(input int idx, input logic [31:0] a, input logic [31:0] b);
        apply(NUM_OPS'(1) << idx, a, b, req_of(idx, b));
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        check("R11", {30'd0, gt_o, eq_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 wraparound, R2 low word
        apply_op(OP_ADD, 32'hFFFF_FFFF, 32'd1);
        apply_op(OP_SUB, 32'd0, 32'd1);
        apply_op(OP_MUL, 32'h0001_0000, 32'h0001_0000);
        apply_op(OP_MUL, 32'hFFFF_FFFF, 32'd7);
        // R3 and R4: rounding toward zero, remainder takes the dividend's sign
        apply_op(OP_DIV, 32'hFFFF_FFF9, 32'd2);
        apply_op(OP_MOD, 32'hFFFF_FFF9, 32'd2);
        apply_op(OP_MOD, 32'd7, 32'hFFFF_FFFE);
        apply_op(OP_DIV, MOST_NEG, 32'hFFFF_FFFF);
        apply_op(OP_MOD, MOST_NEG, 32'hFFFF_FFFF);
        // R8 compare cases
        apply_op(OP_CMP, 32'hFFFF_FFFF, 32'd1);
        apply_op(OP_CMP, 32'd5, 32'd5);
        // R5 and R9: division by zero right after a compare keeps the flags
        apply_op(OP_DIV, 32'd9, 32'd0);
        apply_op(OP_MOD, 32'd9, 32'd0);
        apply_op(OP_CMP, 32'd1, 32'hFFFF_FFFF);
        apply_op(OP_ADD, 32'd3, 32'd3);
        // R10: empty and double selects
        apply('0, 32'd12, 32'd34, "R10");
        apply((NUM_OPS'(1) << OP_CMP) | (NUM_OPS'(1) << OP_ADD), 32'd5, 32'd5, "R10");
        // R6: A has no effect on invert and move
        apply_op(OP_NOT, 32'hDEAD_BEEF, 32'h0F0F_0000);
        apply_op(OP_MOV, 32'h1234_5678, 32'hCAFE_0001);
        // R7: shift edges and amounts of 32 or more
        apply_op(OP_ASR, MOST_NEG, 32'd31);
        apply_op(OP_LSR, MOST_NEG, 32'd31);
        apply_op(OP_LSL, 32'd1, 32'd33);
        apply_op(OP_ASR, MOST_POS, 32'd64);

        for (int k = 0; k < 3000; k++) begin
            int idx;
            idx = $urandom_range(0, NUM_OPS - 1);
            if ($urandom_range(0, 19) == 0) begin
                apply(NUM_OPS'($urandom), pick(), pick(), "R10");
            end else begin
                apply_op(idx, pick(), pick());
            end
        end

        // R11: reset during operation clears the flags
        apply_op(OP_CMP, 32'd8, 32'd2);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R11", {30'd0, gt_o, eq_o}, 32'd0);
        exp_gt = 1'b0;
        exp_eq = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule